// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block collects interrupt events for a small 8-bit processor core and decides which one the core takes next. Seven external pins and twelve internal event lines feed fourteen maskable vectors. Each external pin passes through a two-flop synchronizer. Five of the vectors can be switched, by a select bit, between their own source and a second internal line. Every vector turns the level of its chosen source into a request by detecting an edge. The edge direction is set per vector by a polarity bit. Each vector keeps a request latch and an enable bit. Two more vectors complete the set: a break request from the core and the reset itself. Neither of these can be masked.

At every instruction boundary the core raises `core_ready_i`. If anything is eligible, the block answers in the same cycle with an accept strobe and a 4-bit vector code, and it clears the request it accepted. The core then sets its global disable flag, pushes its state and fetches the vector. The flag is an input to this block. The accept path is a valid/ready pair with the ready side only. `core_ready_i` acts as the ready, and the block never holds an accept over to a later cycle. The rule for back-pressure is simple: while `core_ready_i` is low, no accept happens and every pending request stays latched. The other event inputs are plain levels, and the core may sample them as they are.

Software reaches the request, enable, polarity and select registers through an 8-bit bus with one cycle per write. A read returns the addressed register in the same cycle. Software can clear a request but can never set one. Rewriting a polarity bit or a select bit feeds the new level straight into the edge detector, so such a write can latch a request, exactly as the hardware event path would.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every request, enable, polarity and select bit is 0. The first accept after reset carries vector code 0 (reset), whatever the disable flag and the enables hold.
- R2: An external input is synchronized by two flops, and an internal line is used as it comes. A polarity bit of 0 latches a request on a falling edge of the chosen level, and a polarity bit of 1 latches one on a rising edge. Register map: address 0 holds the request bits for vectors 7..0, address 1 those for vectors 13..8, addresses 2/3 the enables, addresses 4/5 the polarity bits and address 6 the select bits for vectors 4..0.
- R3: Vector k (k < 5) takes external pin k when select bit k is 0 and internal line 7+k when it is 1. The source that is not selected has no effect. Vectors 0..6 are fed by pins 0..6, and vectors 7..13 by internal lines 0..6.
- R4: A maskable vector is accepted only when its request bit is 1, its enable bit is 1 and `gdis_i` is 0. Otherwise its request stays pending.
- R5: A bus write to a request address clears every bit written as 0 and leaves every bit written as 1 unchanged. A bus write never sets a request bit.
- R6: Enable, polarity and select bits read back as written. Bits above vector 13 and above select 4 read as 0.
- R7: A break request is latched and accepted with code 1 even while `gdis_i` is 1.
- R8: Priority is fixed: reset (code 0) first, then break (code 1), then maskable vector v (code v+2), where a lower v wins.
- R9: When maskable vector v is accepted, its request bit is 0 in the next cycle, unless a new hardware event for v arrives in the same cycle.
- R10: If a hardware event and a clear (from the bus or from an accept) hit the same request bit in the same cycle, the bit ends up at 1.
- R11: A write that changes a polarity bit or a select bit so that the chosen effective level goes from inactive to active latches a request for that vector.
- R12: `take_o` is high only in a cycle where `core_ready_i` is high. `take_vec_o` is valid in that cycle, and no accept happens while `core_ready_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_irq_i | input | 7 | External interrupt pins, asynchronous |
| int_irq_i | input | 12 | Internal event levels, synchronous |
| brk_req_i | input | 1 | Break request pulse from the core |
| gdis_i | input | 1 | Global interrupt disable flag from the core |
| core_ready_i | input | 1 | Core is at an instruction boundary and can accept |
| take_o | output | 1 | Accept strobe |
| take_vec_o | output | 4 | Accepted vector code, valid while take_o is high |
| bus_we_i | input | 1 | Register write enable |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data for bus_addr_i |

## Verification
The assertions assume that `core_ready_i` and `gdis_i` are stable levels for the whole of each cycle. They also assume that a request bit can only rise because the edge detectors raised a hit in the cycle before, and that the disable flag is whatever the core holds. The bench changes every input one nanosecond after a rising edge. It raises `core_ready_i` for exactly one cycle per boundary and sets `gdis_i` itself after each maskable accept, the way a core would. In this way every accept lands in a known cycle, and the ordering and masking properties see the same conditions a real core would create.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int VEC_W    = 4;
  localparam int VEC_BASE = 2;
  localparam logic [VEC_W-1:0] VEC_RESET = 4'd0;
  localparam logic [VEC_W-1:0] VEC_BREAK = 4'd1;

  localparam logic [2:0] REG_REQ_LO  = 3'd0;
  localparam logic [2:0] REG_REQ_HI  = 3'd1;
  localparam logic [2:0] REG_EN_LO   = 3'd2;
  localparam logic [2:0] REG_EN_HI   = 3'd3;
  localparam logic [2:0] REG_RISE_LO = 3'd4;
  localparam logic [2:0] REG_RISE_HI = 3'd5;
  localparam logic [2:0] REG_SEL     = 3'd6;

  typedef logic [VEC_W-1:0] vec_code_t;
endpackage

// File: rtl/prio_irq_sync.sv
module prio_irq_sync #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/prio_irq_edge_det.sv
module prio_irq_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic prim_i,
  input  logic alt_i,
  input  logic use_alt_i,
  input  logic rise_sel_i,
  output logic hit_o
);
  logic lvl;
  logic eff;
  logic prev_q;

  // Source choice and polarity sit ahead of the history flop, so a change
  // of either one looks like an edge of the effective level.
  assign lvl   = use_alt_i ? alt_i : prim_i;
  assign eff   = rise_sel_i ? lvl : ~lvl;
  assign hit_o = eff & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= eff;
  end
endmodule

// File: rtl/prio_irq_regbank.sv
module prio_irq_regbank
  import prio_irq_pkg::*;
#(
  parameter int NUM_VEC = 14,
  parameter int NUM_SHR = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_we_i,
  input  logic [2:0]         bus_addr_i,
  input  logic [7:0]         bus_wdata_i,
  output logic [7:0]         bus_rdata_o,
  input  logic [NUM_VEC-1:0] hw_set_i,
  input  logic [NUM_VEC-1:0] acc_clr_i,
  output logic [NUM_VEC-1:0] req_o,
  output logic [NUM_VEC-1:0] en_o,
  output logic [NUM_VEC-1:0] rise_o,
  output logic [NUM_SHR-1:0] sel_o
);
  logic [NUM_VEC-1:0] req_q, en_q, rise_q;
  logic [NUM_SHR-1:0] sel_q;
  logic [NUM_VEC-1:0] sw_clr, en_wr, rise_wr;
  logic [15:0]        wd16;
  logic [15:0]        req16, en16, rise16;
  logic [7:0]         sel8;

  assign wd16 = {bus_wdata_i, bus_wdata_i};

  always_comb begin
    for (int i = 0; i < NUM_VEC; i++) begin
      sw_clr[i]  = bus_we_i && !wd16[i] &&
                   (bus_addr_i == ((i < 8) ? REG_REQ_LO : REG_REQ_HI));
      en_wr[i]   = bus_we_i &&
                   (bus_addr_i == ((i < 8) ? REG_EN_LO : REG_EN_HI));
      rise_wr[i] = bus_we_i &&
                   (bus_addr_i == ((i < 8) ? REG_RISE_LO : REG_RISE_HI));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      en_q   <= '0;
      rise_q <= '0;
      sel_q  <= '0;
    end else begin
      // A hardware event outranks any clear in the same cycle.
      req_q <= (req_q & ~sw_clr & ~acc_clr_i) | hw_set_i;
      for (int i = 0; i < NUM_VEC; i++) begin
        if (en_wr[i])   en_q[i]   <= wd16[i];
        if (rise_wr[i]) rise_q[i] <= wd16[i];
      end
      if (bus_we_i && bus_addr_i == REG_SEL) sel_q <= bus_wdata_i[NUM_SHR-1:0];
    end
  end

  always_comb begin
    req16  = '0;
    en16   = '0;
    rise16 = '0;
    sel8   = '0;
    req16[NUM_VEC-1:0]  = req_q;
    en16[NUM_VEC-1:0]   = en_q;
    rise16[NUM_VEC-1:0] = rise_q;
    sel8[NUM_SHR-1:0]   = sel_q;
    case (bus_addr_i)
      REG_REQ_LO:  bus_rdata_o = req16[7:0];
      REG_REQ_HI:  bus_rdata_o = req16[15:8];
      REG_EN_LO:   bus_rdata_o = en16[7:0];
      REG_EN_HI:   bus_rdata_o = en16[15:8];
      REG_RISE_LO: bus_rdata_o = rise16[7:0];
      REG_RISE_HI: bus_rdata_o = rise16[15:8];
      REG_SEL:     bus_rdata_o = sel8;
      default:     bus_rdata_o = '0;
    endcase
  end

  assign req_o  = req_q;
  assign en_o   = en_q;
  assign rise_o = rise_q;
  assign sel_o  = sel_q;
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
  import prio_irq_pkg::*;
#(
  parameter int NUM_VEC = 14
) (
  input  logic               rst_pend_i,
  input  logic               brk_pend_i,
  input  logic [NUM_VEC-1:0] req_i,
  input  logic [NUM_VEC-1:0] en_i,
  input  logic               gdis_i,
  input  logic               ready_i,
  output logic               take_o,
  output vec_code_t          vec_o,
  output logic               take_rst_o,
  output logic               take_brk_o,
  output logic [NUM_VEC-1:0] grant_o
);
  logic [NUM_VEC-1:0] elig;
  logic               any_mask;
  vec_code_t          mask_code;
  logic [NUM_VEC-1:0] mask_oh;

  assign elig = req_i & en_i & {NUM_VEC{~gdis_i}};

  // Scan from the top down so the lowest eligible index is left standing.
  always_comb begin
    any_mask  = 1'b0;
    mask_code = '0;
    mask_oh   = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        any_mask  = 1'b1;
        mask_code = VEC_W'(i) + VEC_W'(VEC_BASE);
        mask_oh   = '0;
        mask_oh[i] = 1'b1;
      end
    end
  end

  always_comb begin
    take_rst_o = 1'b0;
    take_brk_o = 1'b0;
    grant_o    = '0;
    vec_o      = '0;
    take_o     = 1'b0;
    if (ready_i) begin
      if (rst_pend_i) begin
        take_o     = 1'b1;
        take_rst_o = 1'b1;
        vec_o      = VEC_RESET;
      end else if (brk_pend_i) begin
        take_o     = 1'b1;
        take_brk_o = 1'b1;
        vec_o      = VEC_BREAK;
      end else if (any_mask) begin
        take_o  = 1'b1;
        grant_o = mask_oh;
        vec_o   = mask_code;
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_EXT = 7,
  parameter int NUM_VEC = 14,
  parameter int NUM_SHR = 5,
  localparam int NUM_INT = NUM_VEC - NUM_EXT + NUM_SHR
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EXT-1:0] ext_irq_i,
  input  logic [NUM_INT-1:0] int_irq_i,
  input  logic               brk_req_i,
  input  logic               gdis_i,
  input  logic               core_ready_i,
  output logic               take_o,
  output logic [VEC_W-1:0]   take_vec_o,
  input  logic               bus_we_i,
  input  logic [2:0]         bus_addr_i,
  input  logic [7:0]         bus_wdata_i,
  output logic [7:0]         bus_rdata_o
);
  logic [NUM_EXT-1:0] ext_sync;
  logic [NUM_VEC-1:0] hw_set, grant, req_q, en_q, rise_q;
  logic [NUM_SHR-1:0] sel_q;
  logic               rst_pend_q, brk_pend_q;
  logic               take_rst, take_brk;
  vec_code_t          vec_c;

  prio_irq_sync #(.W(NUM_EXT)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(ext_irq_i), .sync_o(ext_sync)
  );

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    logic prim, alt, use_alt;
    if (v < NUM_EXT) begin : g_ext
      assign prim = ext_sync[v];
    end else begin : g_int
      assign prim = int_irq_i[v-NUM_EXT];
    end
    if (v < NUM_SHR) begin : g_shr
      assign alt     = int_irq_i[NUM_VEC-NUM_EXT+v];
      assign use_alt = sel_q[v];
    end else begin : g_solo
      assign alt     = 1'b0;
      assign use_alt = 1'b0;
    end
    prio_irq_edge_det u_det (
      .clk_i(clk_i), .rst_ni(rst_ni), .prim_i(prim), .alt_i(alt),
      .use_alt_i(use_alt), .rise_sel_i(rise_q[v]), .hit_o(hw_set[v])
    );
  end

  prio_irq_regbank #(.NUM_VEC(NUM_VEC), .NUM_SHR(NUM_SHR)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .hw_set_i(hw_set),
    .acc_clr_i(grant), .req_o(req_q), .en_o(en_q), .rise_o(rise_q), .sel_o(sel_q)
  );

  prio_irq_arbiter #(.NUM_VEC(NUM_VEC)) u_arb (
    .rst_pend_i(rst_pend_q), .brk_pend_i(brk_pend_q), .req_i(req_q), .en_i(en_q),
    .gdis_i(gdis_i), .ready_i(core_ready_i), .take_o(take_o), .vec_o(vec_c),
    .take_rst_o(take_rst), .take_brk_o(take_brk), .grant_o(grant)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pend_q <= 1'b1;
      brk_pend_q <= 1'b0;
    end else begin
      if (take_rst) rst_pend_q <= 1'b0;
      brk_pend_q <= (brk_pend_q & ~take_brk) | brk_req_i;
    end
  end

  assign take_vec_o = vec_c;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
  import prio_irq_pkg::*;
#(
  parameter int NUM_VEC = 14
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               take_i,
  input logic [VEC_W-1:0]   vec_i,
  input logic               ready_i,
  input logic               gdis_i,
  input logic [NUM_VEC-1:0] req_i,
  input logic [NUM_VEC-1:0] en_i,
  input logic [NUM_VEC-1:0] hw_set_i,
  input logic               rst_pend_i,
  input logic               brk_pend_i
);
  logic [NUM_VEC-1:0] elig;
  assign elig = req_i & en_i & {NUM_VEC{~gdis_i}};

  AST_TAKE_NEEDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> ready_i); // R12

  AST_RESET_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_pend_i && ready_i) |-> (take_i && vec_i == VEC_RESET)); // R1

  AST_BREAK_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_pend_i && !rst_pend_i && ready_i) |-> (take_i && vec_i == VEC_BREAK)); // R7

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_v
    localparam logic [NUM_VEC-1:0] LOWER = NUM_VEC'((64'(1) << v) - 64'(1));
    localparam logic [VEC_W-1:0]   CODE  = VEC_W'(v + VEC_BASE);

    AST_MASK_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_i && vec_i == CODE) |-> (!gdis_i && en_i[v] && req_i[v])); // R4

    AST_FIXED_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_i && vec_i == CODE) |-> (!rst_pend_i && !brk_pend_i && (elig & LOWER) == '0)); // R8

    AST_ACCEPT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_i && vec_i == CODE) |=> (!req_i[v] || $past(hw_set_i[v]))); // R9

    AST_NO_SOFT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(req_i[v]) |-> $past(hw_set_i[v])); // R5
  end
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NUM_VEC(NUM_VEC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .take_i(take_o), .vec_i(take_vec_o),
  .ready_i(core_ready_i), .gdis_i(gdis_i), .req_i(req_q), .en_i(en_q),
  .hw_set_i(hw_set), .rst_pend_i(rst_pend_q), .brk_pend_i(brk_pend_q)
);

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  ext = 7'h7F;
  logic [11:0] intl = '0;
  logic        brk = 1'b0;
  logic        gdis = 1'b1;
  logic        ready = 1'b0;
  logic        take;
  logic [3:0]  tvec;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ext_irq_i(ext), .int_irq_i(intl),
    .brk_req_i(brk), .gdis_i(gdis), .core_ready_i(ready), .take_o(take),
    .take_vec_o(tvec), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    step(1);
    we = 1'b1; addr = a; wdata = d;
    step(1);
    we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input int exp);
    step(1);
    addr = a;
    #1;
    chk(tag, int'(rdata), exp);
  endtask

  // Driver: queue the expected code, then open one instruction boundary.
  task automatic boundary(input bit expect_take, input int code, input string tag);
    if (expect_take) begin
      exp_q.push_back(code);
      tag_q.push_back(tag);
    end
    step(1);
    ready = 1'b1;
    step(1);
    ready = 1'b0;
    if (expect_take) chk({tag, " accept seen"}, exp_q.size(), 0);
  endtask

  // Monitor: every accept must match the head of the scoreboard.
  always @(negedge clk) begin
    if (take) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R12 unexpected accept: actual 0x%0h expected none", tvec);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({t, " vector code"}, int'(tvec), e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R12 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(5);
    rst_n = 1'b1;
    step(3);
    // R1 reset state
    for (int a = 0; a < 7; a++) rd_chk("R1 reset register", 3'(a), 0);
    // R8 / R7: break waits behind reset, both pass the disable flag
    step(1); brk = 1'b1; step(1); brk = 1'b0;
    boundary(1'b1, 0, "R1");
    boundary(1'b1, 1, "R7");

    // R2 falling edge on pin 3 through the synchronizer
    bus_wr(3'd2, 8'h08);
    step(1); ext[3] = 1'b0; step(4);
    rd_chk("R2 falling edge", 3'd0, 8'h08);
    boundary(1'b0, 0, "R4");
    rd_chk("R4 masked by disable flag", 3'd0, 8'h08);
    gdis = 1'b0;
    boundary(1'b1, 5, "R4");
    gdis = 1'b1;
    rd_chk("R9 cleared on accept", 3'd0, 8'h00);
    // R2 rising edge, polarity change with low level gives no edge
    bus_wr(3'd4, 8'h08);
    step(2);
    rd_chk("R2 polarity write no edge", 3'd0, 8'h00);
    step(1); ext[3] = 1'b1; step(4);
    rd_chk("R2 rising edge", 3'd0, 8'h08);
    bus_wr(3'd0, 8'hF7);
    rd_chk("R5 zero clears", 3'd0, 8'h00);
    bus_wr(3'd0, 8'hFF);
    rd_chk("R5 one never sets", 3'd0, 8'h00);

    // R4 disabled vector stays pending
    step(1); ext[6] = 1'b0; step(4);
    gdis = 1'b0;
    boundary(1'b0, 0, "R4");
    gdis = 1'b1;
    rd_chk("R4 disabled vector pending", 3'd0, 8'h40);
    bus_wr(3'd0, 8'h00);

    // R8 lower index first: vectors 2 and 9
    bus_wr(3'd2, 8'h04);
    bus_wr(3'd3, 8'h02);
    step(1); ext[2] = 1'b0; intl[2] = 1'b1; step(2); intl[2] = 1'b0; step(4);
    rd_chk("R8 both pending lo", 3'd0, 8'h04);
    rd_chk("R8 both pending hi", 3'd1, 8'h02);
    gdis = 1'b0;
    boundary(1'b1, 4, "R8");
    gdis = 1'b1;
    rd_chk("R9 winner cleared", 3'd0, 8'h00);
    rd_chk("R8 loser still pending", 3'd1, 8'h02);
    gdis = 1'b0;
    boundary(1'b1, 11, "R8");
    gdis = 1'b1;

    // R6 readback
    bus_wr(3'd2, 8'hA5);
    rd_chk("R6 enable lo", 3'd2, 8'hA5);
    bus_wr(3'd3, 8'hFF);
    rd_chk("R6 enable hi width", 3'd3, 8'h3F);
    rd_chk("R6 polarity lo", 3'd4, 8'h08);
    bus_wr(3'd2, 8'h00);
    bus_wr(3'd3, 8'h00);

    // R11 polarity change on idle-high pin 5
    bus_wr(3'd4, 8'h28);
    step(2);
    rd_chk("R11 polarity flip latches", 3'd0, 8'h20);
    bus_wr(3'd0, 8'h00);
    // R11 select change on vector 1 (pin high, alternate low)
    bus_wr(3'd6, 8'h02);
    step(2);
    rd_chk("R11 select flip latches", 3'd0, 8'h02);
    rd_chk("R6 select readback", 3'd6, 8'h02);
    bus_wr(3'd0, 8'h00);
    // R3 unselected pin ignored, alternate line used
    step(1); ext[1] = 1'b0; step(5);
    rd_chk("R3 unselected pin ignored", 3'd0, 8'h00);
    ext[1] = 1'b1;
    step(1); intl[8] = 1'b1; step(2); intl[8] = 1'b0; step(3);
    rd_chk("R3 alternate source", 3'd0, 8'h02);
    bus_wr(3'd0, 8'h00);

    // R10 hardware event on vector 10 against a bus clear in the same cycle
    step(1); intl[3] = 1'b1; step(2);
    step(1);
    we = 1'b1; addr = 3'd1; wdata = 8'h00; intl[3] = 1'b0;
    step(1);
    we = 1'b0;
    rd_chk("R10 set beats clear", 3'd1, 8'h04);

    // R12 no accept without ready, then accept of vector 10
    bus_wr(3'd3, 8'h04);
    gdis = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R12 idle without ready", int'(take), 0);
    end
    boundary(1'b1, 12, "R12");
    gdis = 1'b1;
    rd_chk("R9 vector 10 cleared", 3'd1, 8'h00);

    step(2);
    chk("R9 scoreboard drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule